// File: doc/BRIEF.md
# Exclusive Access Monitor for an AXI3 Memory Port

This block sits between AXI3 masters and a single memory slave and enforces load-exclusive / store-exclusive semantics for that memory. A read carrying the lock attribute opens a reservation that records the requester's transaction ID and the 8-byte granule of its address. A later locked write succeeds only if that reservation is still live and matches on both ID and granule. A successful locked write is answered with EXOKAY and reaches memory unchanged. A failed one is answered with OKAY and reaches memory with every byte strobe cleared, so that the store-exclusive reports failure and leaves the location untouched.

Ordinary writes that land in the reserved granule end the reservation. A dedicated clear input ends it on demand, which a processor uses on a context switch or when it clears its exclusive state. A locked read that arrives while a reservation is open replaces it. The address, write-data and read-address channels pass straight through, except for flow control. Write data is held back until the monitor has judged the write address it belongs to. Responses are matched to their requests in order through small flag queues.

Top module: `excl_mon`

## Requirements
- R1: After reset no reservation exists. A locked write issued before any locked read completes with response 2'b00 and has all strobes of its data beats driven as zero toward memory.
- R2: A read accepted with s_arlock=1 records its ID and its address bits [ADDR_W-1:3] as the reservation. When memory answers the read with 2'b00, its response to the master is 2'b01 (EXOKAY).
- R3: A locked write whose ID equals the reservation ID and whose address bits [ADDR_W-1:3] equal the reserved granule completes with 2'b01 and passes its strobes unchanged. It ends the reservation, so a repeat of the same locked write fails.
- R4: A write with s_awlock=0 whose start address falls in the reserved granule ends the reservation whatever its ID. A write with s_awlock=0 to any other granule leaves the reservation in place.
- R5: A one-cycle pulse on clr_excl ends the reservation. A locked write accepted in the same cycle as the pulse fails, and a locked read accepted in that cycle does not open a reservation.
- R6: A locked write that finds no live reservation, a different ID or a different granule completes with 2'b00, has all strobes forced to zero toward memory, and leaves any reservation as it was.
- R7: A locked read accepted while a reservation is open replaces the recorded ID and granule with its own.
- R8: When a write address and a locked read address are accepted in the same cycle, the write is judged against the reservation held before that cycle, and afterwards the reservation is the one opened by the read.
- R9: Unlocked transfers pass through with the memory's response unchanged. An error response from memory (2'b10 or 2'b11) reaches the master unchanged, even for locked transfers.
- R10: No write-data beat reaches memory before its write address has been accepted. Write and read responses are paired with requests in issue order, which assumes that the memory answers in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_excl | input | 1 | Pulse that ends the reservation |
| s_awvalid | input | 1 | Write address valid from master |
| s_awready | output | 1 | Write address ready to master |
| s_awid | input | ID_W | Write transaction ID |
| s_awaddr | input | ADDR_W | Write start address |
| s_awlen | input | LEN_W | Write burst length minus one |
| s_awlock | input | 1 | Write is exclusive |
| s_wvalid | input | 1 | Write data valid from master |
| s_wready | output | 1 | Write data ready to master |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wlast | input | 1 | Last beat of write burst |
| s_bvalid | output | 1 | Write response valid to master |
| s_bready | input | 1 | Write response ready from master |
| s_bid | output | ID_W | Write response ID |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid from master |
| s_arready | output | 1 | Read address ready to master |
| s_arid | input | ID_W | Read transaction ID |
| s_araddr | input | ADDR_W | Read start address |
| s_arlen | input | LEN_W | Read burst length minus one |
| s_arlock | input | 1 | Read is exclusive |
| s_rvalid | output | 1 | Read data valid to master |
| s_rready | input | 1 | Read data ready from master |
| s_rid | output | ID_W | Read data ID |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| s_rlast | output | 1 | Last read beat |
| m_awvalid | output | 1 | Write address valid to memory |
| m_awready | input | 1 | Write address ready from memory |
| m_awid | output | ID_W | Write ID to memory |
| m_awaddr | output | ADDR_W | Write address to memory |
| m_awlen | output | LEN_W | Write length to memory |
| m_wvalid | output | 1 | Write data valid to memory |
| m_wready | input | 1 | Write data ready from memory |
| m_wdata | output | DATA_W | Write data to memory |
| m_wstrb | output | DATA_W/8 | Strobes to memory, zero for a failed exclusive |
| m_wlast | output | 1 | Last write beat to memory |
| m_bvalid | input | 1 | Write response valid from memory |
| m_bready | output | 1 | Write response ready to memory |
| m_bid | input | ID_W | Write response ID from memory |
| m_bresp | input | 2 | Write response code from memory |
| m_arvalid | output | 1 | Read address valid to memory |
| m_arready | input | 1 | Read address ready from memory |
| m_arid | output | ID_W | Read ID to memory |
| m_araddr | output | ADDR_W | Read address to memory |
| m_arlen | output | LEN_W | Read length to memory |
| m_rvalid | input | 1 | Read data valid from memory |
| m_rready | output | 1 | Read data ready to memory |
| m_rid | input | ID_W | Read data ID from memory |
| m_rdata | input | DATA_W | Read data from memory |
| m_rresp | input | 2 | Read response code from memory |
| m_rlast | input | 1 | Last read beat from memory |

## Verification
Two pairs of functions can collide in one cycle. The first is a write address and a locked read address accepted on the same clock edge. The bench provokes this by releasing both channels at the same falling edge into an always-ready memory. In one case a winning locked write of an old reservation meets a new locked read. In the other an ordinary write into a granule meets a locked read of the other word of that granule. The outcome is judged by a follow-up locked write from the reading ID, which must win. The second pair is clr_excl raised in the very cycle a locked write address is accepted. That write must come back 2'b00 with zero strobes.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

   // Verdict attached to each accepted write address
   typedef enum logic [1:0] {
      WK_PLAIN   = 2'd0,
      WK_EX_WIN  = 2'd1,
      WK_EX_LOSE = 2'd2
   } wr_kind_e;

   localparam logic [1:0] RESP_OKAY   = 2'b00;
   localparam logic [1:0] RESP_EXOKAY = 2'b01;

endpackage

// File: rtl/excl_mon_fifo.sv
module excl_mon_fifo #(
   parameter int W     = 2,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int PTR_W = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
      $error("excl_mon_fifo: DEPTH must be a power of two, at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("excl_mon_fifo: W must be positive");
   end

   logic [W-1:0]   store [DEPTH];
   logic [PTR_W:0] wp, rp;

   assign empty = (wp == rp);
   assign full  = (wp[PTR_W] != rp[PTR_W]) && (wp[PTR_W-1:0] == rp[PTR_W-1:0]);
   assign dout  = store[rp[PTR_W-1:0]];

   always_ff @(posedge clk) begin
      if (push) begin
         store[wp[PTR_W-1:0]] <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
      end
   end

   // R10: the queues stay consistent with the traffic they track
   a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/excl_mon_resv.sv
module excl_mon_resv
   import excl_mon_pkg::*;
#(
   parameter int ID_W  = 4,
   parameter int TAG_W = 29
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             wr_fire_i,
   input  logic             wr_lock_i,
   input  logic [ID_W-1:0]  wr_id_i,
   input  logic [TAG_W-1:0] wr_tag_i,
   input  logic             rd_fire_i,
   input  logic             rd_lock_i,
   input  logic [ID_W-1:0]  rd_id_i,
   input  logic [TAG_W-1:0] rd_tag_i,
   output wr_kind_e         wr_kind_o
);
   if (ID_W < 1 || TAG_W < 1) begin : g_bad_par
      $error("excl_mon_resv: ID_W and TAG_W must be positive");
   end

   logic             res_vld;
   logic [ID_W-1:0]  res_id;
   logic [TAG_W-1:0] res_tag;

   logic live, hit, win, kill, install;

   // A clear in the same cycle already counts against the write
   assign live    = res_vld & ~clr_i;
   assign hit     = live & (wr_tag_i == res_tag);
   assign win     = wr_lock_i & hit & (wr_id_i == res_id);
   assign kill    = wr_fire_i & hit & (~wr_lock_i | win);
   assign install = rd_fire_i & rd_lock_i;

   always_comb begin
      if (!wr_lock_i)  wr_kind_o = WK_PLAIN;
      else if (win)    wr_kind_o = WK_EX_WIN;
      else             wr_kind_o = WK_EX_LOSE;
   end

   // Priority: clear, then a new exclusive read, then write invalidation
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_vld <= 1'b0;
         res_id  <= '0;
         res_tag <= '0;
      end else if (clr_i) begin
         res_vld <= 1'b0;
      end else if (install) begin
         res_vld <= 1'b1;
         res_id  <= rd_id_i;
         res_tag <= rd_tag_i;
      end else if (kill) begin
         res_vld <= 1'b0;
      end
   end

   a_r2_read_installs: assert property (@(posedge clk) disable iff (!rst_n)
      install && !clr_i |=> res_vld && res_id == $past(rd_id_i) && res_tag == $past(rd_tag_i));
   a_r3_win_ends: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire_i && wr_kind_o == WK_EX_WIN && !install |=> !res_vld);
   a_r4_plain_hit_ends: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire_i && !wr_lock_i && res_vld && wr_tag_i == res_tag && !install |=> !res_vld);
   a_r4_plain_miss_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire_i && !wr_lock_i && wr_tag_i != res_tag && !install && !clr_i
      |=> res_vld == $past(res_vld));
   a_r5_clear_ends: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !res_vld);
   a_r5_clear_blocks_win: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |-> wr_kind_o != WK_EX_WIN);
   a_r6_lose_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire_i && wr_kind_o == WK_EX_LOSE && !install && !clr_i
      |=> res_vld == $past(res_vld) && $stable(res_id));
   a_r8_read_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
      install && wr_fire_i && !clr_i |=> res_vld && res_id == $past(rd_id_i));

endmodule

// File: rtl/excl_mon.sv
module excl_mon
   import excl_mon_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int ID_W       = 4,
   parameter int DATA_W     = 32,
   parameter int LEN_W      = 4,
   parameter int GRANULE_LG = 3,
   parameter int DEPTH      = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr_excl,
   input  logic                  s_awvalid,
   output logic                  s_awready,
   input  logic [ID_W-1:0]       s_awid,
   input  logic [ADDR_W-1:0]     s_awaddr,
   input  logic [LEN_W-1:0]      s_awlen,
   input  logic                  s_awlock,
   input  logic                  s_wvalid,
   output logic                  s_wready,
   input  logic [DATA_W-1:0]     s_wdata,
   input  logic [DATA_W/8-1:0]   s_wstrb,
   input  logic                  s_wlast,
   output logic                  s_bvalid,
   input  logic                  s_bready,
   output logic [ID_W-1:0]       s_bid,
   output logic [1:0]            s_bresp,
   input  logic                  s_arvalid,
   output logic                  s_arready,
   input  logic [ID_W-1:0]       s_arid,
   input  logic [ADDR_W-1:0]     s_araddr,
   input  logic [LEN_W-1:0]      s_arlen,
   input  logic                  s_arlock,
   output logic                  s_rvalid,
   input  logic                  s_rready,
   output logic [ID_W-1:0]       s_rid,
   output logic [DATA_W-1:0]     s_rdata,
   output logic [1:0]            s_rresp,
   output logic                  s_rlast,
   output logic                  m_awvalid,
   input  logic                  m_awready,
   output logic [ID_W-1:0]       m_awid,
   output logic [ADDR_W-1:0]     m_awaddr,
   output logic [LEN_W-1:0]      m_awlen,
   output logic                  m_wvalid,
   input  logic                  m_wready,
   output logic [DATA_W-1:0]     m_wdata,
   output logic [DATA_W/8-1:0]   m_wstrb,
   output logic                  m_wlast,
   input  logic                  m_bvalid,
   output logic                  m_bready,
   input  logic [ID_W-1:0]       m_bid,
   input  logic [1:0]            m_bresp,
   output logic                  m_arvalid,
   input  logic                  m_arready,
   output logic [ID_W-1:0]       m_arid,
   output logic [ADDR_W-1:0]     m_araddr,
   output logic [LEN_W-1:0]      m_arlen,
   input  logic                  m_rvalid,
   output logic                  m_rready,
   input  logic [ID_W-1:0]       m_rid,
   input  logic [DATA_W-1:0]     m_rdata,
   input  logic [1:0]            m_rresp,
   input  logic                  m_rlast
);
   localparam int TAG_W  = ADDR_W - GRANULE_LG;
   localparam int STRB_W = DATA_W / 8;
   localparam int KIND_W = $bits(wr_kind_e);

   if (GRANULE_LG < 0 || GRANULE_LG >= ADDR_W) begin : g_bad_granule
      $error("excl_mon: GRANULE_LG must lie in [0, ADDR_W)");
   end
   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_data
      $error("excl_mon: DATA_W must be a multiple of 8");
   end

   // ---------------- granule tags ----------------
   logic [TAG_W-1:0] aw_tag, ar_tag;

   if (GRANULE_LG == 0) begin : g_tag_exact
      assign aw_tag = s_awaddr;
      assign ar_tag = s_araddr;
   end else begin : g_tag_gran
      assign aw_tag = s_awaddr[ADDR_W-1:GRANULE_LG];
      assign ar_tag = s_araddr[ADDR_W-1:GRANULE_LG];
   end

   // ---------------- queue status ----------------
   logic              wq_empty, wq_full, bq_empty, bq_full, rq_empty, rq_full;
   logic [KIND_W-1:0] wq_dout, bq_dout, aw_kind_bits;
   logic [0:0]        rq_dout, ar_lock_bits;
   wr_kind_e          aw_kind, w_kind, b_kind;

   // ---------------- write address ----------------
   logic aw_ok, aw_fire;

   assign aw_ok     = ~wq_full & ~bq_full;
   assign m_awvalid = s_awvalid & aw_ok;
   assign s_awready = m_awready & aw_ok;
   assign aw_fire   = s_awvalid & s_awready;
   assign m_awid    = s_awid;
   assign m_awaddr  = s_awaddr;
   assign m_awlen   = s_awlen;

   // ---------------- read address ----------------
   logic ar_fire;

   assign m_arvalid    = s_arvalid & ~rq_full;
   assign s_arready    = m_arready & ~rq_full;
   assign ar_fire      = s_arvalid & s_arready;
   assign m_arid       = s_arid;
   assign m_araddr     = s_araddr;
   assign m_arlen      = s_arlen;
   assign ar_lock_bits = s_arlock;

   // ---------------- reservation ----------------
   excl_mon_resv #(
      .ID_W  (ID_W),
      .TAG_W (TAG_W)
   ) u_resv (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clr_excl),
      .wr_fire_i (aw_fire),
      .wr_lock_i (s_awlock),
      .wr_id_i   (s_awid),
      .wr_tag_i  (aw_tag),
      .rd_fire_i (ar_fire),
      .rd_lock_i (s_arlock),
      .rd_id_i   (s_arid),
      .rd_tag_i  (ar_tag),
      .wr_kind_o (aw_kind)
   );

   assign aw_kind_bits = aw_kind;

   // ---------------- verdict queues ----------------
   logic wq_pop, bq_pop, rq_pop;

   excl_mon_fifo #(.W(KIND_W), .DEPTH(DEPTH)) u_wq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (aw_fire),
      .din   (aw_kind_bits),
      .pop   (wq_pop),
      .dout  (wq_dout),
      .empty (wq_empty),
      .full  (wq_full)
   );

   excl_mon_fifo #(.W(KIND_W), .DEPTH(DEPTH)) u_bq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (aw_fire),
      .din   (aw_kind_bits),
      .pop   (bq_pop),
      .dout  (bq_dout),
      .empty (bq_empty),
      .full  (bq_full)
   );

   excl_mon_fifo #(.W(1), .DEPTH(DEPTH)) u_rq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (ar_fire),
      .din   (ar_lock_bits),
      .pop   (rq_pop),
      .dout  (rq_dout),
      .empty (rq_empty),
      .full  (rq_full)
   );

   assign w_kind = wr_kind_e'(wq_dout);
   assign b_kind = wr_kind_e'(bq_dout);

   // ---------------- write data ----------------
   assign m_wvalid = s_wvalid & ~wq_empty;
   assign s_wready = m_wready & ~wq_empty;
   assign wq_pop   = s_wvalid & s_wready & s_wlast;
   assign m_wdata  = s_wdata;
   assign m_wlast  = s_wlast;
   assign m_wstrb  = (w_kind == WK_EX_LOSE) ? {STRB_W{1'b0}} : s_wstrb;

   // ---------------- write response ----------------
   assign s_bvalid = m_bvalid;
   assign m_bready = s_bready;
   assign s_bid    = m_bid;
   assign bq_pop   = m_bvalid & m_bready;

   always_comb begin
      s_bresp = m_bresp;
      if (m_bresp == RESP_OKAY && b_kind == WK_EX_WIN) begin
         s_bresp = RESP_EXOKAY;
      end else if (m_bresp == RESP_EXOKAY && b_kind != WK_EX_WIN) begin
         s_bresp = RESP_OKAY;
      end
   end

   // ---------------- read response ----------------
   assign s_rvalid = m_rvalid;
   assign m_rready = s_rready;
   assign s_rid    = m_rid;
   assign s_rdata  = m_rdata;
   assign s_rlast  = m_rlast;
   assign rq_pop   = m_rvalid & m_rready & m_rlast;

   always_comb begin
      s_rresp = m_rresp;
      if (m_rresp == RESP_OKAY && rq_dout[0]) begin
         s_rresp = RESP_EXOKAY;
      end
   end

   // R10: memory never answers more than was issued
   a_r10_b_tracked: assert property (@(posedge clk) disable iff (!rst_n)
      m_bvalid |-> !bq_empty);
   a_r10_r_tracked: assert property (@(posedge clk) disable iff (!rst_n)
      m_rvalid |-> !rq_empty);
   // R10: no data beat toward memory without a judged address
   a_r10_w_after_aw: assert property (@(posedge clk) disable iff (!rst_n)
      m_wvalid |-> !wq_empty);

endmodule

// File: tb/excl_mon_tb.sv
`timescale 1ns/1ps
module excl_mon_tb;
   localparam int AW = 32;
   localparam int IW = 4;
   localparam int DW = 32;
   localparam int LW = 4;
   localparam int SW = DW / 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr_excl = 1'b0;

   logic          s_awvalid = 0, s_awready, s_awlock = 0;
   logic [IW-1:0] s_awid = '0;
   logic [AW-1:0] s_awaddr = '0;
   logic [LW-1:0] s_awlen = '0;
   logic          s_wvalid = 0, s_wready, s_wlast = 0;
   logic [DW-1:0] s_wdata = '0;
   logic [SW-1:0] s_wstrb = '0;
   logic          s_bvalid, s_bready = 1'b1;
   logic [IW-1:0] s_bid;
   logic [1:0]    s_bresp;
   logic          s_arvalid = 0, s_arready, s_arlock = 0;
   logic [IW-1:0] s_arid = '0;
   logic [AW-1:0] s_araddr = '0;
   logic [LW-1:0] s_arlen = '0;
   logic          s_rvalid, s_rready = 1'b1, s_rlast;
   logic [IW-1:0] s_rid;
   logic [DW-1:0] s_rdata;
   logic [1:0]    s_rresp;

   logic          m_awvalid, m_awready;
   logic [IW-1:0] m_awid;
   logic [AW-1:0] m_awaddr;
   logic [LW-1:0] m_awlen;
   logic          m_wvalid, m_wready, m_wlast;
   logic [DW-1:0] m_wdata;
   logic [SW-1:0] m_wstrb;
   logic          m_bvalid, m_bready;
   logic [IW-1:0] m_bid;
   logic [1:0]    m_bresp;
   logic          m_arvalid, m_arready;
   logic [IW-1:0] m_arid;
   logic [AW-1:0] m_araddr;
   logic [LW-1:0] m_arlen;
   logic          m_rvalid, m_rready, m_rlast;
   logic [IW-1:0] m_rid;
   logic [DW-1:0] m_rdata;
   logic [1:0]    m_rresp;

   always #2 clk = ~clk;

   excl_mon u_dut (
      .clk(clk), .rst_n(rst_n), .clr_excl(clr_excl),
      .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awid(s_awid), .s_awaddr(s_awaddr),
      .s_awlen(s_awlen), .s_awlock(s_awlock),
      .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wlast(s_wlast),
      .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bid(s_bid), .s_bresp(s_bresp),
      .s_arvalid(s_arvalid), .s_arready(s_arready), .s_arid(s_arid), .s_araddr(s_araddr),
      .s_arlen(s_arlen), .s_arlock(s_arlock),
      .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rid(s_rid), .s_rdata(s_rdata),
      .s_rresp(s_rresp), .s_rlast(s_rlast),
      .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awid(m_awid), .m_awaddr(m_awaddr), .m_awlen(m_awlen),
      .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast),
      .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bid(m_bid), .m_bresp(m_bresp),
      .m_arvalid(m_arvalid), .m_arready(m_arready), .m_arid(m_arid), .m_araddr(m_araddr), .m_arlen(m_arlen),
      .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rid(m_rid), .m_rdata(m_rdata),
      .m_rresp(m_rresp), .m_rlast(m_rlast)
   );

   // ---------------- behavioural memory slave ----------------
   assign m_awready = 1'b1;
   assign m_wready  = 1'b1;
   assign m_arready = 1'b1;

   logic [DW-1:0] mem [16];
   logic [IW-1:0] sl_awid [$];
   logic [AW-1:0] sl_awaddr [$];
   logic [IW-1:0] sl_bid [$];
   logic [1:0]    sl_bresp [$];
   logic [IW-1:0] sl_rid [$];
   logic [DW-1:0] sl_rdata [$];
   logic [1:0]    sl_rresp [$];

   always @(posedge clk) begin
      if (!rst_n) begin
         sl_awid.delete(); sl_awaddr.delete(); sl_bid.delete(); sl_bresp.delete();
         sl_rid.delete(); sl_rdata.delete(); sl_rresp.delete();
         m_bvalid <= 1'b0; m_bid <= '0; m_bresp <= '0;
         m_rvalid <= 1'b0; m_rid <= '0; m_rdata <= '0; m_rresp <= '0; m_rlast <= 1'b0;
      end else begin
         if (m_bvalid && m_bready && sl_bid.size() != 0) begin
            void'(sl_bid.pop_front()); void'(sl_bresp.pop_front());
         end
         if (m_rvalid && m_rready && sl_rid.size() != 0) begin
            void'(sl_rid.pop_front()); void'(sl_rdata.pop_front()); void'(sl_rresp.pop_front());
         end
         if (m_awvalid && m_awready) begin
            sl_awid.push_back(m_awid); sl_awaddr.push_back(m_awaddr);
         end
         if (m_wvalid && m_wready && sl_awaddr.size() != 0) begin
            logic [AW-1:0] a;
            a = sl_awaddr.pop_front();
            sl_bid.push_back(sl_awid.pop_front());
            if (a[6]) begin
               sl_bresp.push_back(2'b10);
            end else begin
               for (int i = 0; i < SW; i++)
                  if (m_wstrb[i]) mem[a[5:2]][8*i +: 8] = m_wdata[8*i +: 8];
               sl_bresp.push_back(2'b00);
            end
         end
         if (m_arvalid && m_arready) begin
            sl_rid.push_back(m_arid);
            sl_rdata.push_back(m_araddr[6] ? '0 : mem[m_araddr[5:2]]);
            sl_rresp.push_back(m_araddr[6] ? 2'b10 : 2'b00);
         end
         m_bvalid <= (sl_bid.size() != 0);
         m_bid    <= (sl_bid.size() != 0) ? sl_bid[0] : '0;
         m_bresp  <= (sl_bresp.size() != 0) ? sl_bresp[0] : '0;
         m_rvalid <= (sl_rid.size() != 0);
         m_rid    <= (sl_rid.size() != 0) ? sl_rid[0] : '0;
         m_rdata  <= (sl_rdata.size() != 0) ? sl_rdata[0] : '0;
         m_rresp  <= (sl_rresp.size() != 0) ? sl_rresp[0] : '0;
         m_rlast  <= (sl_rid.size() != 0);
      end
   end

   // ---------------- reference model ----------------
   int n_cmp = 0;
   int n_bad = 0;

   bit            ref_vld = 0;
   logic [IW-1:0] ref_id = '0;
   logic [28:0]   ref_gran = '0;
   logic [DW-1:0] ref_mem [16];

   logic [IW-1:0] eb_id [$];
   logic [1:0]    eb_resp [$];
   string         eb_tag [$];
   logic [SW-1:0] ew_strb [$];
   string         ew_tag [$];
   logic [IW-1:0] er_id [$];
   logic [DW-1:0] er_data [$];
   logic [1:0]    er_resp [$];
   string         er_tag [$];

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic void model_write(input logic [IW-1:0] id, input logic [AW-1:0] addr,
                                       input bit lock, input logic [SW-1:0] strb,
                                       input logic [DW-1:0] data, input bit clr_now,
                                       input string tag);
      bit live, hit, win, err;
      logic [SW-1:0] eff;
      if (clr_now) ref_vld = 0;
      live = ref_vld;
      hit  = live && (addr[31:3] == ref_gran);
      win  = lock && hit && (id == ref_id);
      err  = addr[6];
      eff  = (lock && !win) ? '0 : strb;
      ew_strb.push_back(eff); ew_tag.push_back(tag);
      if (!err)
         for (int i = 0; i < SW; i++)
            if (eff[i]) ref_mem[addr[5:2]][8*i +: 8] = data[8*i +: 8];
      if (hit && (!lock || win)) ref_vld = 0;
      eb_id.push_back(id);
      eb_resp.push_back(err ? 2'b10 : (win ? 2'b01 : 2'b00));
      eb_tag.push_back(tag);
   endfunction

   function automatic void model_read(input logic [IW-1:0] id, input logic [AW-1:0] addr,
                                      input bit lock, input string tag);
      if (lock) begin
         ref_vld = 1; ref_id = id; ref_gran = addr[31:3];
      end
      er_id.push_back(id);
      er_data.push_back(addr[6] ? '0 : ref_mem[addr[5:2]]);
      er_resp.push_back(addr[6] ? 2'b10 : (lock ? 2'b01 : 2'b00));
      er_tag.push_back(tag);
   endfunction

   // compared every cycle, just before the rising edge
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         if (s_bvalid) begin
            if (eb_resp.size() == 0) check(0, "R10", "unexpected write response", 1, 0);
            else begin
               string t;
               logic [1:0] er;
               logic [IW-1:0] ei;
               t = eb_tag.pop_front(); er = eb_resp.pop_front(); ei = eb_id.pop_front();
               check(s_bresp == er, t, "bresp", s_bresp, er);
               check(s_bid == ei, "R10", "bid", s_bid, ei);
            end
         end
         if (m_wvalid && m_wready) begin
            if (ew_strb.size() == 0) check(0, "R10", "unexpected data beat", 1, 0);
            else begin
               string t;
               logic [SW-1:0] es;
               t = ew_tag.pop_front(); es = ew_strb.pop_front();
               check(m_wstrb == es, t, "wstrb", m_wstrb, es);
            end
         end
         if (s_rvalid) begin
            if (er_resp.size() == 0) check(0, "R10", "unexpected read response", 1, 0);
            else begin
               string t;
               logic [1:0] rr;
               logic [DW-1:0] rd;
               logic [IW-1:0] ri;
               t = er_tag.pop_front(); rr = er_resp.pop_front(); rd = er_data.pop_front();
               ri = er_id.pop_front();
               check(s_rresp == rr, t, "rresp", s_rresp, rr);
               check(s_rdata == rd, t, "rdata", s_rdata, rd);
               check(s_rid == ri, "R10", "rid", s_rid, ri);
            end
         end
      end
   end

   // ---------------- drivers ----------------
   task automatic drive_aw(input logic [IW-1:0] id, input logic [AW-1:0] addr, input bit lock);
      @(negedge clk);
      s_awvalid = 1; s_awid = id; s_awaddr = addr; s_awlock = lock; s_awlen = '0;
      #1;
      while (!s_awready) begin @(negedge clk); #1; end
      @(negedge clk);
      s_awvalid = 0; s_awlock = 0;
   endtask

   task automatic drive_w(input logic [DW-1:0] data, input logic [SW-1:0] strb);
      @(negedge clk);
      s_wvalid = 1; s_wdata = data; s_wstrb = strb; s_wlast = 1;
      #1;
      while (!s_wready) begin @(negedge clk); #1; end
      @(negedge clk);
      s_wvalid = 0; s_wlast = 0;
   endtask

   task automatic drive_ar(input logic [IW-1:0] id, input logic [AW-1:0] addr, input bit lock);
      @(negedge clk);
      s_arvalid = 1; s_arid = id; s_araddr = addr; s_arlock = lock; s_arlen = '0;
      #1;
      while (!s_arready) begin @(negedge clk); #1; end
      @(negedge clk);
      s_arvalid = 0; s_arlock = 0;
   endtask

   task automatic drain();
      while (eb_resp.size() != 0 || er_resp.size() != 0 || ew_strb.size() != 0) @(negedge clk);
   endtask

   task automatic do_write(input logic [IW-1:0] id, input logic [AW-1:0] addr, input bit lock,
                           input logic [DW-1:0] data, input string tag);
      model_write(id, addr, lock, 4'hF, data, 0, tag);
      fork
         drive_aw(id, addr, lock);
         drive_w(data, 4'hF);
      join
      drain();
   endtask

   task automatic do_read(input logic [IW-1:0] id, input logic [AW-1:0] addr, input bit lock,
                          input string tag);
      model_read(id, addr, lock, tag);
      drive_ar(id, addr, lock);
      drain();
   endtask

   task automatic pulse_clr();
      @(negedge clk); clr_excl = 1;
      @(negedge clk); clr_excl = 0;
      ref_vld = 0;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL R10 watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      for (int i = 0; i < 16; i++) begin
         mem[i] = 32'hA000_0000 + i;
         ref_mem[i] = 32'hA000_0000 + i;
      end
      repeat (4) @(negedge clk);
      rst_n = 1;
      #1;
      // R1: quiet outputs after reset
      check(s_bvalid == 0, "R1", "s_bvalid", s_bvalid, 0);
      check(s_rvalid == 0, "R1", "s_rvalid", s_rvalid, 0);
      check(s_awready == 1, "R1", "s_awready", s_awready, 1);
      check(s_wready == 0, "R10", "s_wready idle", s_wready, 0);

      // R9: plain traffic untouched
      do_write(4'd1, 32'h10, 0, 32'h1111_0010, "R9");
      do_read (4'd1, 32'h10, 0, "R9");
      // R1: exclusive write with no reservation since reset
      do_write(4'd1, 32'h14, 1, 32'hDEAD_0014, "R1");
      do_read (4'd2, 32'h14, 0, "R1");

      // R2 / R3: matching pair wins, then the reservation is spent
      do_read (4'd1, 32'h10, 1, "R2");
      do_write(4'd1, 32'h14, 1, 32'h3333_0014, "R3");
      do_read (4'd1, 32'h14, 0, "R3");
      do_write(4'd1, 32'h10, 1, 32'hBAD0_0010, "R3");

      // R4: plain write in the granule kills, elsewhere keeps
      do_read (4'd2, 32'h20, 1, "R2");
      do_write(4'd5, 32'h24, 0, 32'h4444_0024, "R4");
      do_write(4'd2, 32'h20, 1, 32'hBAD0_0020, "R4");
      do_read (4'd2, 32'h20, 0, "R6");
      do_read (4'd2, 32'h20, 1, "R2");
      do_write(4'd5, 32'h28, 0, 32'h4444_0028, "R4");
      do_write(4'd2, 32'h20, 1, 32'h4444_0020, "R4");

      // R6: other ID fails and keeps the reservation; other granule fails
      do_read (4'd3, 32'h30, 1, "R2");
      do_write(4'd4, 32'h30, 1, 32'hBAD0_0030, "R6");
      do_write(4'd3, 32'h08, 1, 32'hBAD0_0008, "R6");
      do_write(4'd3, 32'h30, 1, 32'h6666_0030, "R6");

      // R7: newer exclusive read replaces the older one
      do_read (4'd1, 32'h08, 1, "R7");
      do_read (4'd2, 32'h18, 1, "R7");
      do_write(4'd1, 32'h08, 1, 32'hBAD1_0008, "R7");
      do_write(4'd2, 32'h18, 1, 32'h7777_0018, "R7");

      // R5: clear pulse, then clear in the same cycle as the write
      do_read (4'd1, 32'h08, 1, "R2");
      pulse_clr();
      do_write(4'd1, 32'h08, 1, 32'hBAD2_0008, "R5");
      do_read (4'd1, 32'h08, 1, "R2");
      model_write(4'd1, 32'h08, 1, 4'hF, 32'hBAD3_0008, 1, "R5");
      fork
         begin @(negedge clk); clr_excl = 1; @(negedge clk); clr_excl = 0; end
         drive_aw(4'd1, 32'h08, 1);
         drive_w(32'hBAD3_0008, 4'hF);
      join
      drain();
      do_read (4'd1, 32'h08, 0, "R5");

      // R8: write and exclusive read accepted together
      do_read (4'd6, 32'h30, 1, "R2");
      model_write(4'd6, 32'h30, 1, 4'hF, 32'h8888_0030, 0, "R8");
      model_read (4'd7, 32'h38, 1, "R8");
      fork
         drive_aw(4'd6, 32'h30, 1);
         drive_w(32'h8888_0030, 4'hF);
         drive_ar(4'd7, 32'h38, 1);
      join
      drain();
      do_write(4'd7, 32'h38, 1, 32'h8888_0038, "R8");
      model_write(4'd1, 32'h38, 0, 4'hF, 32'h8888_1038, 0, "R8");
      model_read (4'd7, 32'h3C, 1, "R8");
      fork
         drive_aw(4'd1, 32'h38, 0);
         drive_w(32'h8888_1038, 4'hF);
         drive_ar(4'd7, 32'h3C, 1);
      join
      drain();
      do_write(4'd7, 32'h3C, 1, 32'h8888_003C, "R8");

      // R9: errors pass through on exclusive traffic
      do_read (4'd1, 32'h48, 1, "R9");
      do_write(4'd1, 32'h48, 1, 32'h9999_0048, "R9");

      // R10: data offered before its address is held off
      model_write(4'd2, 32'h04, 0, 4'hF, 32'hAAAA_0004, 0, "R10");
      fork
         drive_w(32'hAAAA_0004, 4'hF);
         begin
            repeat (3) begin
               @(negedge clk); #1;
               check(m_wvalid == 0, "R10", "m_wvalid early", m_wvalid, 0);
               check(s_wready == 0, "R10", "s_wready early", s_wready, 0);
            end
            drive_aw(4'd2, 32'h04, 0);
         end
      join
      drain();
      do_read (4'd2, 32'h04, 0, "R10");

      repeat (4) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule